// File: doc/BRIEF.md
# DMA Dispatcher Run-Control Unit

This unit owns the control word of a scatter-gather DMA dispatcher and decides, every cycle, whether the dispatcher may hand a new descriptor to the read and write engines and whether those engines may receive further transfer commands. Several independent causes can halt issue: a software halt, a descriptor-only halt, a latched write-side error, a latched early-termination event, a full response FIFO and an ongoing soft reset. The unit reports "stopped" only once a halt is requested and both engines have gone idle, so in-flight accesses always finish first.

A soft reset is requested through the control word. The unit raises an engine reset and a visible resetting flag. It waits for both engines to drain, holds for a fixed number of cycles, and then returns the whole control word to its running default. Completion interrupts pass through an enable mask that sits in front of the interrupt latch, so events that arrive while the mask is off are never recorded. The latched interrupt is cleared by writing a one to its status bit.

Register access is a single-cycle write strobe with a one-bit address. Address 0 selects the control word and address 1 selects the status word. Read data is combinational from the addressed word.

Top module: `dma_dispatch_ctl`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0, both cmd_go and desc_go are 1, irq and eng_rst are 0.
- R2: Control bits are halt=bit0, soft reset=bit1, stop on error=bit2, stop on early termination=bit3, interrupt enable=bit4, descriptor halt=bit5. A write to address 0 takes effect at the next clock edge, and bits 31:6 always read 0.
- R3: While control bit0 is 1, cmd_go and desc_go are 0. Both change in the cycle right after the write edge.
- R4: Status bit0 (stopped) is a register that is 1 one cycle after a cycle in which a halt cause (control bit0, control bit5, status bit3 or status bit4) was active and both rd_idle and wr_idle were 1. It is 0 otherwise.
- R5: Control bit5 forces desc_go to 0 and leaves cmd_go unaffected.
- R6: An err_evt while control bit2 is 1 sets status bit3, which forces cmd_go and desc_go to 0. An err_evt while control bit2 is 0 is ignored. Writing 1 to status bit3 clears it.
- R7: An early_evt while control bit3 is 1 sets status bit4 with the same blocking effect. An early_evt while control bit3 is 0 is ignored. Writing 1 to status bit4 clears it.
- R8: While resp_full is 1, cmd_go and desc_go are 0 in that same cycle.
- R9: A done_evt sets status bit2 only if control bit4 is 1 at that edge; masked events are lost. Writing 1 to status bit2 clears it, a set in the same cycle wins, and irq equals status bit2.
- R10: A control write with bit1 set, made while not resetting, raises eng_rst and status bit1 from the next cycle, blocks all issue, and clears status bits 2 to 4.
- R11: Resetting lasts while either engine is busy, then for HOLD_CYC further cycles. It drops at the same edge as the control word returns to 0.
- R12: Control writes made while resetting is 1 have no effect.
- R13: Writing 0 to the control word and clearing status bits 3 and 4 makes cmd_go and desc_go 1 again and drops stopped one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 control word, 1 status word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data of the addressed word |
| rd_idle | input | 1 | Read engine has nothing in flight |
| wr_idle | input | 1 | Write engine has nothing in flight |
| err_evt | input | 1 | Error seen at the write engine sink |
| early_evt | input | 1 | Packet longer than descriptor length |
| done_evt | input | 1 | Descriptor completion event |
| resp_full | input | 1 | Response FIFO full |
| cmd_go | output | 1 | Engines may take transfer commands |
| desc_go | output | 1 | A new descriptor may be dispatched |
| eng_rst | output | 1 | Reset to engines and FIFOs |
| irq | output | 1 | Latched interrupt |

## Verification
cmd_go and desc_go are combinational in resp_full and registered state. They are due in the same cycle as resp_full, and one edge after a control write or a latched event. Stopped, the event latches and write-one-to-clear take exactly one edge. Resetting rises one edge after the request and falls HOLD_CYC+1 edges after the first cycle that sees both engines idle. The bench applies inputs on the falling edge, advances a behavioural model on the rising edge, and compares every output one falling edge later, so each result is checked in the cycle it is due.

// File: rtl/dma_dctl_pkg.sv
package dma_dctl_pkg;
  localparam int CTL_W = 6;
  localparam int STS_W = 5;

  localparam int CB_HALT   = 0;
  localparam int CB_SRST   = 1;
  localparam int CB_ERRSTP = 2;
  localparam int CB_ELYSTP = 3;
  localparam int CB_IRQEN  = 4;
  localparam int CB_DSCSTP = 5;

  localparam int SB_STOPPED = 0;
  localparam int SB_RESET   = 1;
  localparam int SB_IRQ     = 2;
  localparam int SB_ERRHLT  = 3;
  localparam int SB_ELYHLT  = 4;

  typedef struct packed {
    logic desc_stop;
    logic irq_en;
    logic early_stop;
    logic err_stop;
    logic srst;
    logic halt;
  } ctl_t;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_DRAIN = 2'd1,
    RS_HOLD  = 2'd2
  } rs_state_t;
endpackage

// File: rtl/dctl_rstseq.sv
module dctl_rstseq
  import dma_dctl_pkg::*;
#(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic engines_idle,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_CYC - 1);

  rs_state_t        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    done   = 1'b0;
    unique case (st_q)
      RS_IDLE: begin
        if (start) st_d = RS_DRAIN;
      end
      RS_DRAIN: begin
        if (engines_idle) begin
          st_d   = RS_HOLD;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      RS_HOLD: begin
        if (cnt_q == CNT_LAST) begin
          st_d = RS_IDLE;
          done = 1'b1;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= RS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (st_q != RS_IDLE);
endmodule

// File: rtl/dctl_regs.sv
module dctl_regs
  import dma_dctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rs_busy,
  input  logic              rs_done,
  input  logic              stopped,
  input  logic              err_evt,
  input  logic              early_evt,
  input  logic              done_evt,
  output logic              rs_start,
  output ctl_t              ctl,
  output logic              err_halt,
  output logic              early_halt,
  output logic              irq_flag,
  output logic [DATA_W-1:0] rdata
);
  localparam int PAD_CTL = DATA_W - CTL_W;
  localparam int PAD_STS = DATA_W - STS_W;

  ctl_t ctl_q, ctl_d;
  logic err_q, err_d;
  logic ely_q, ely_d;
  logic irq_q, irq_d;
  logic ctl_wr, sts_wr;
  logic ctl_en, lat_en;
  logic [STS_W-1:0] sts_vec;
  logic unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CTL_W];

  always_comb begin
    ctl_wr   = wr_en && (addr == 1'b0) && !rs_busy;
    sts_wr   = wr_en && (addr == 1'b1);
    rs_start = ctl_wr && wdata[CB_SRST];

    ctl_en = ctl_wr || rs_done;
    ctl_d  = ctl_q;
    if (rs_done) begin
      ctl_d = '0;
    end else if (ctl_wr) begin
      ctl_d = ctl_t'(wdata[CTL_W-1:0]);
    end

    err_d = err_q;
    if (rs_start) begin
      err_d = 1'b0;
    end else if (ctl_q.err_stop && err_evt) begin
      err_d = 1'b1;
    end else if (sts_wr && wdata[SB_ERRHLT]) begin
      err_d = 1'b0;
    end

    ely_d = ely_q;
    if (rs_start) begin
      ely_d = 1'b0;
    end else if (ctl_q.early_stop && early_evt) begin
      ely_d = 1'b1;
    end else if (sts_wr && wdata[SB_ELYHLT]) begin
      ely_d = 1'b0;
    end

    irq_d = irq_q;
    if (rs_start) begin
      irq_d = 1'b0;
    end else if (ctl_q.irq_en && done_evt) begin
      irq_d = 1'b1;
    end else if (sts_wr && wdata[SB_IRQ]) begin
      irq_d = 1'b0;
    end

    lat_en = rs_start || sts_wr || err_evt || early_evt || done_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      ely_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (lat_en) begin
      err_q <= err_d;
      ely_q <= ely_d;
      irq_q <= irq_d;
    end
  end

  always_comb begin
    sts_vec             = '0;
    sts_vec[SB_STOPPED] = stopped;
    sts_vec[SB_RESET]   = rs_busy;
    sts_vec[SB_IRQ]     = irq_q;
    sts_vec[SB_ERRHLT]  = err_q;
    sts_vec[SB_ELYHLT]  = ely_q;
    if (addr == 1'b0) begin
      rdata = {{PAD_CTL{1'b0}}, ctl_q};
    end else begin
      rdata = {{PAD_STS{1'b0}}, sts_vec};
    end
  end

  assign ctl        = ctl_q;
  assign err_halt   = err_q;
  assign early_halt = ely_q;
  assign irq_flag   = irq_q;
endmodule

// File: rtl/dctl_gate.sv
module dctl_gate
  import dma_dctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl,
  input  logic err_halt,
  input  logic early_halt,
  input  logic resp_full,
  input  logic rs_busy,
  input  logic rd_idle,
  input  logic wr_idle,
  output logic cmd_go,
  output logic desc_go,
  output logic stopped
);
  logic stop_req;
  logic cmd_block;
  logic stp_q, stp_d;

  always_comb begin
    stop_req  = ctl.halt || ctl.desc_stop || err_halt || early_halt;
    cmd_block = ctl.halt || err_halt || early_halt || resp_full || rs_busy;
    cmd_go    = !cmd_block;
    desc_go   = !cmd_block && !ctl.desc_stop;
    stp_d     = stop_req && rd_idle && wr_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stp_q <= 1'b0;
    end else begin
      stp_q <= stp_d;
    end
  end

  assign stopped = stp_q;
endmodule

// File: rtl/dma_dispatch_ctl.sv
module dma_dispatch_ctl
  import dma_dctl_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int HOLD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rd_idle,
  input  logic              wr_idle,
  input  logic              err_evt,
  input  logic              early_evt,
  input  logic              done_evt,
  input  logic              resp_full,
  output logic              cmd_go,
  output logic              desc_go,
  output logic              eng_rst,
  output logic              irq
);
  ctl_t             ctl;
  logic [CTL_W-1:0] ctl_word;
  logic             rs_start, rs_busy, rs_done;
  logic             err_halt, early_halt, irq_flag, stopped;

  dctl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rs_busy   (rs_busy),
    .rs_done   (rs_done),
    .stopped   (stopped),
    .err_evt   (err_evt),
    .early_evt (early_evt),
    .done_evt  (done_evt),
    .rs_start  (rs_start),
    .ctl       (ctl),
    .err_halt  (err_halt),
    .early_halt(early_halt),
    .irq_flag  (irq_flag),
    .rdata     (reg_rdata)
  );

  dctl_rstseq #(.HOLD_CYC(HOLD_CYC)) u_rst (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (rs_start),
    .engines_idle(rd_idle && wr_idle),
    .busy        (rs_busy),
    .done        (rs_done)
  );

  dctl_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .err_halt  (err_halt),
    .early_halt(early_halt),
    .resp_full (resp_full),
    .rs_busy   (rs_busy),
    .rd_idle   (rd_idle),
    .wr_idle   (wr_idle),
    .cmd_go    (cmd_go),
    .desc_go   (desc_go),
    .stopped   (stopped)
  );

  assign ctl_word = ctl;
  assign eng_rst  = rs_busy;
  assign irq      = irq_flag;
endmodule

// File: rtl/dma_dctl_chk.sv
module dma_dctl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        ctl_word,
  input logic              resetting,
  input logic              stopped,
  input logic              irq,
  input logic              cmd_go,
  input logic              desc_go,
  input logic              resp_full,
  input logic              rd_idle,
  input logic              wr_idle,
  input logic              reg_addr,
  input logic [DATA_W-1:0] reg_rdata
);
  // R2
  ctl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 1'b0) |-> (reg_rdata[DATA_W-1:6] == '0));

  // R4
  stopped_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(rd_idle && wr_idle));

  // R8
  full_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_full |-> (!cmd_go && !desc_go));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctl_word[4]));

  // R10
  reset_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> (!cmd_go && !desc_go));

  // R11
  reset_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resetting) |=> resetting);

  // R11
  reset_clears_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetting) |-> (ctl_word == 6'd0));
endmodule

bind dma_dispatch_ctl dma_dctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctl_word (ctl_word),
  .resetting(eng_rst),
  .stopped  (stopped),
  .irq      (irq),
  .cmd_go   (cmd_go),
  .desc_go  (desc_go),
  .resp_full(resp_full),
  .rd_idle  (rd_idle),
  .wr_idle  (wr_idle),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata)
);

// File: tb/sim_dma_dispatch_ctl.sv
`timescale 1ns/1ps
module sim_dma_dispatch_ctl;
  localparam int DW   = 32;
  localparam int HOLD = 4;

  logic          clk;
  logic          rst_n;
  logic          reg_wr, reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          rd_idle, wr_idle, err_evt, early_evt, done_evt, resp_full;
  logic          cmd_go, desc_go, eng_rst, irq;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [5:0] m_ctl;
  bit m_err, m_ely, m_irq, m_stp;
  int m_rs;
  int m_cnt;

  dma_dispatch_ctl #(.DATA_W(DW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_idle(rd_idle),
    .wr_idle(wr_idle), .err_evt(err_evt), .early_evt(early_evt),
    .done_evt(done_evt), .resp_full(resp_full), .cmd_go(cmd_go),
    .desc_go(desc_go), .eng_rst(eng_rst), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit ctl_wr, start, done, sw, halt_req;
    logic [5:0] n_ctl;
    bit n_err, n_ely, n_irq, n_stp;
    ctl_wr   = reg_wr && !reg_addr && (m_rs == 0);
    sw       = reg_wr && reg_addr;
    start    = ctl_wr && reg_wdata[1];
    done     = (m_rs == 2) && (m_cnt == HOLD - 1);
    halt_req = m_ctl[0] || m_ctl[5] || m_err || m_ely;
    n_ctl = done ? 6'd0 : (ctl_wr ? reg_wdata[5:0] : m_ctl);
    n_err = start ? 0 : (m_ctl[2] && err_evt) ? 1 : (sw && reg_wdata[3]) ? 0 : m_err;
    n_ely = start ? 0 : (m_ctl[3] && early_evt) ? 1 : (sw && reg_wdata[4]) ? 0 : m_ely;
    n_irq = start ? 0 : (m_ctl[4] && done_evt) ? 1 : (sw && reg_wdata[2]) ? 0 : m_irq;
    n_stp = halt_req && rd_idle && wr_idle;
    case (m_rs)
      0: if (start) m_rs = 1;
      1: if (rd_idle && wr_idle) begin m_rs = 2; m_cnt = 0; end
      default: if (m_cnt == HOLD - 1) m_rs = 0; else m_cnt++;
    endcase
    m_ctl = n_ctl; m_err = n_err; m_ely = n_ely; m_irq = n_irq; m_stp = n_stp;
  endtask

  task automatic compare();
    bit rs, blk;
    logic [31:0] exp_rd;
    rs  = (m_rs != 0);
    blk = m_ctl[0] || m_err || m_ely || resp_full || rs;
    exp_rd = reg_addr ? {27'd0, m_ely, m_err, m_irq, rs, m_stp} : {26'd0, m_ctl};
    chk("cmd_go", 32'(cmd_go), 32'(!blk));
    chk("desc_go", 32'(desc_go), 32'(!blk && !m_ctl[5]));
    chk("eng_rst", 32'(eng_rst), 32'(rs));
    chk("irq", 32'(irq), 32'(m_irq));
    chk("rdata", reg_rdata, exp_rd);
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(bit a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(); s = 1'b0;
  endtask

  task automatic look(int n);
    for (int i = 0; i < n; i++) begin
      reg_addr = 1'b0; step();
      reg_addr = 1'b1; step();
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    rd_idle = 1; wr_idle = 1; err_evt = 0; early_evt = 0; done_evt = 0; resp_full = 0;
    m_ctl = '0; m_err = 0; m_ely = 0; m_irq = 0; m_stp = 0; m_rs = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1'b1;
    look(2);

    cur_req = "R2";
    wr(1'b0, 32'hFFFF_FFD0);
    look(1);

    cur_req = "R9";
    pulse(done_evt);
    look(1);
    wr(1'b1, 32'h4);
    look(1);
    wr(1'b0, 32'h0);
    pulse(done_evt);
    look(1);
    wr(1'b0, 32'h10);
    done_evt = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 32'h4; step();
    done_evt = 0; reg_wr = 0; reg_wdata = '0;
    look(1);
    wr(1'b1, 32'h4);

    cur_req = "R3";
    wr_idle = 0;
    wr(1'b0, 32'h1);
    cur_req = "R4";
    look(2);
    wr_idle = 1;
    look(2);

    cur_req = "R13";
    wr(1'b0, 32'h0);
    look(1);

    cur_req = "R5";
    rd_idle = 0;
    wr(1'b0, 32'h20);
    look(1);
    rd_idle = 1;
    look(1);
    wr(1'b0, 32'h0);

    cur_req = "R6";
    pulse(err_evt);
    look(1);
    wr(1'b0, 32'h4);
    pulse(err_evt);
    look(2);
    cur_req = "R13";
    wr(1'b1, 32'h8);
    wr(1'b0, 32'h0);
    look(1);

    cur_req = "R7";
    pulse(early_evt);
    look(1);
    wr(1'b0, 32'h8);
    pulse(early_evt);
    look(2);
    wr(1'b1, 32'h10);
    wr(1'b0, 32'h0);
    look(1);

    cur_req = "R8";
    resp_full = 1;
    look(1);
    resp_full = 0;
    look(1);

    cur_req = "R10";
    wr(1'b0, 32'h1C);
    pulse(done_evt);
    pulse(err_evt);
    look(1);
    rd_idle = 0;
    wr(1'b0, 32'h1E);
    look(1);
    cur_req = "R12";
    wr(1'b0, 32'h21);
    look(1);
    cur_req = "R11";
    rd_idle = 1;
    look(HOLD + 2);
    wr(1'b0, 32'h2);
    look(HOLD);

    summary();
  end
endmodule